// File: doc/BRIEF.md
# Serial-Acknowledge Vectored Interrupt Chain

This block joins a row of device interface cells to one shared interrupt-request line and hands out a single acknowledge that ripples through the cells in index order. Each cell keeps a pending flag that its device sets with a one-cycle raise pulse, and a fixed 8-bit vector code chosen by parameter. The request line is the OR of every cell's enabled pending flag. A device-side enable masks a cell's request without discarding it.

A processor-side controller watches the shared line. When the line is high and the processor reports it is ready, the controller drives the acknowledge for exactly one cycle. Inside the chain, a cell that is not requesting passes the acknowledge to its neighbour. The first requesting cell keeps the acknowledge, places its vector on the shared vector bus and clears its pending flag when the cycle ends. The controller latches the bus at the end of that cycle and reports either a valid vector or an error if no cell answered. Cell 0 sits nearest the controller and has the highest priority.

Top module: `irq_daisy_chain`

## Requirements
- R1: `intr_line` is high in a cycle exactly when at least one cell has its pending flag set and its `dev_en` bit high; it follows `dev_en` combinationally.
- R2: A high `dev_raise[i]` at a rising edge sets cell i's pending flag, and the flag stays set until that cell wins an acknowledge.
- R3: A cell whose `dev_en` bit is low neither drives `intr_line` nor takes the acknowledge, and it keeps its pending flag so that it is served once enabled again.
- R4: When `intr_line` and `cpu_ready` are both high at a rising edge and `int_ack` is low, `int_ack` is high for the next cycle only. After every acknowledge cycle there is at least one cycle with `int_ack` low.
- R5: `int_ack` never rises after an edge at which `cpu_ready` was low.
- R6: The acknowledge passes through cells that are not requesting. The cell with the lowest index that is requesting and enabled wins, and it blocks the acknowledge from every cell above it.
- R7: During an acknowledge cycle, `data_bus` carries the winner's vector, `VEC_BASE + i*VEC_STEP` (8 bits, modulo 256). At most one cell drives the bus. At all other times `data_bus` is 0.
- R8: At the edge that ends an acknowledge cycle with a winner, `vec_code` takes the winner's vector, `vec_valid` is high for one cycle, and the winner's pending flag clears.
- R9: A raise that arrives during an acknowledge cycle does not change that cycle's winner or its vector. It leaves the raising cell pending for a later acknowledge, and this holds even when the raising cell is the current winner.
- R10: If no enabled cell is requesting during an acknowledge cycle, then at its closing edge `ack_error` is high for one cycle, `vec_valid` stays low and `vec_code` becomes 0.
- R11: While `rst` is high at a rising edge, every pending flag clears and `intr_line`, `int_ack`, `vec_valid`, `ack_error`, `vec_code` and `data_bus` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_raise | input | N_DEV | One-cycle request pulses, one per cell |
| dev_en | input | N_DEV | Device-side request enables, one per cell |
| cpu_ready | input | 1 | Processor can accept an interrupt |
| intr_line | output | 1 | Shared interrupt-request line |
| int_ack | output | 1 | Acknowledge entering cell 0 |
| data_bus | output | 8 | Shared vector bus, driven by the winning cell |
| vec_valid | output | 1 | One-cycle pulse: `vec_code` holds a fresh vector |
| vec_code | output | 8 | Latched vector from the last acknowledge |
| ack_error | output | 1 | One-cycle pulse: acknowledge went unanswered |

## Verification
The bench builds the block with six cells, a vector base of 0x20 and a step of 3. These values move the vector pattern away from its defaults, so a chain-position or vector-arithmetic slip shows up as a wrong code. The short chain means that a random mix of raises, enable drops and processor stalls often lands several requests in the same acknowledge window. That pressure reaches the priority order, raises that collide with the acknowledge cycle, and the unanswered-acknowledge case within a few hundred cycles.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int VEC_W = 8;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_ACK  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic error;
        vec_t code;
    } capture_t;

    function automatic vec_t cell_vector(vec_t base, vec_t step, int idx);
        return base + vec_t'(idx) * step;
    endfunction

endpackage

// File: rtl/irq_cell.sv
module irq_cell
    import irq_chain_pkg::*;
#(
    parameter vec_t VEC = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic enable,
    input  logic ack_in,
    output logic ack_out,
    output logic req,
    output logic grant,
    output vec_t bus_out
);

    logic pend_q;

    // request is visible only while the device allows it
    assign req     = pend_q & enable;
    assign grant   = ack_in & req;
    assign ack_out = ack_in & ~req;
    assign bus_out = grant ? VEC : '0;

    // a new raise wins over the clear, so a colliding event is kept
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (raise) begin
            pend_q <= 1'b1;
        end else if (grant) begin
            pend_q <= 1'b0;
        end
    end

    // R8
    cell_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !raise) |=> !pend_q);

    // R2
    cell_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(raise));

    // R9
    cell_keep_chk: assert property (@(posedge clk) disable iff (rst)
        raise |=> pend_q);

endmodule

// File: rtl/irq_chain.sv
module irq_chain
    import irq_chain_pkg::*;
#(
    parameter int   N_DEV    = 8,
    parameter vec_t VEC_BASE = 8'h40,
    parameter vec_t VEC_STEP = 8'h04
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] raise,
    input  logic [N_DEV-1:0] enable,
    input  logic             ack,
    output logic             intr,
    output vec_t             bus,
    output logic             any_grant
);

    logic [N_DEV:0]            ack_link;
    logic [N_DEV-1:0]          req;
    logic [N_DEV-1:0]          grant;
    logic [N_DEV-1:0][VEC_W-1:0] bus_part;

    assign ack_link[0] = ack;

    for (genvar i = 0; i < N_DEV; i++) begin : g_cell
        irq_cell #(
            .VEC(cell_vector(VEC_BASE, VEC_STEP, i))
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .raise  (raise[i]),
            .enable (enable[i]),
            .ack_in (ack_link[i]),
            .ack_out(ack_link[i+1]),
            .req    (req[i]),
            .grant  (grant[i]),
            .bus_out(bus_part[i])
        );
    end

    // wired-OR request line and wired-OR vector bus
    assign intr      = |req;
    assign any_grant = |grant;

    always_comb begin
        bus = '0;
        for (int i = 0; i < N_DEV; i++) begin
            bus = bus | bus_part[i];
        end
    end

    // R7
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R6
    grant_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> ack);

    // R7
    bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (bus == '0));

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_chain_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     intr,
    input  logic     cpu_ready,
    input  vec_t     bus,
    input  logic     any_grant,
    output logic     int_ack,
    output capture_t cap
);

    ctl_state_e state_q;

    assign int_ack = (state_q == CTL_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            cap     <= '0;
        end else begin
            case (state_q)
                CTL_IDLE: begin
                    cap.valid <= 1'b0;
                    cap.error <= 1'b0;
                    if (intr && cpu_ready) begin
                        state_q <= CTL_ACK;
                    end
                end
                CTL_ACK: begin
                    state_q   <= CTL_IDLE;
                    cap.valid <= any_grant;
                    cap.error <= ~any_grant;
                    cap.code  <= bus;
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !int_ack);

    // R5
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_ack) |-> $past(intr && cpu_ready));

    // R10
    ack_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> (cap.valid ^ cap.error));

    // R8
    valid_only_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cap.valid) |-> $past(int_ack));

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int   N_DEV    = 8,
    parameter vec_t VEC_BASE = 8'h40,
    parameter vec_t VEC_STEP = 8'h04
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] dev_raise,
    input  logic [N_DEV-1:0] dev_en,
    input  logic             cpu_ready,
    output logic             intr_line,
    output logic             int_ack,
    output logic [7:0]       data_bus,
    output logic             vec_valid,
    output logic [7:0]       vec_code,
    output logic             ack_error
);

    vec_t     bus;
    logic     any_grant;
    capture_t cap;

    irq_chain #(
        .N_DEV   (N_DEV),
        .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .raise    (dev_raise),
        .enable   (dev_en),
        .ack      (int_ack),
        .intr     (intr_line),
        .bus      (bus),
        .any_grant(any_grant)
    );

    irq_ack_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .intr     (intr_line),
        .cpu_ready(cpu_ready),
        .bus      (bus),
        .any_grant(any_grant),
        .int_ack  (int_ack),
        .cap      (cap)
    );

    assign data_bus  = bus;
    assign vec_valid = cap.valid;
    assign vec_code  = cap.code;
    assign ack_error = cap.error;

    // R10
    error_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ack_error |-> (vec_code == 8'h00));

endmodule

// File: tb/sim_irq_daisy_chain.sv
module sim_irq_daisy_chain;

    localparam int       N    = 6;
    localparam bit [7:0] BASE = 8'h20;
    localparam bit [7:0] STEP = 8'h03;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_raise = '0;
    logic [N-1:0] dev_en = '1;
    logic         cpu_ready = 1'b0;
    logic         intr_line, int_ack, vec_valid, ack_error;
    logic [7:0]   data_bus, vec_code;

    int n_chk  = 0;
    int n_fail = 0;
    string phase = "R11";

    always #10 clk = ~clk;

    irq_daisy_chain #(.N_DEV(N), .VEC_BASE(BASE), .VEC_STEP(STEP)) u0 (
        .clk(clk), .rst(rst), .dev_raise(dev_raise), .dev_en(dev_en),
        .cpu_ready(cpu_ready), .intr_line(intr_line), .int_ack(int_ack),
        .data_bus(data_bus), .vec_valid(vec_valid), .vec_code(vec_code),
        .ack_error(ack_error)
    );

    // behavioural reference
    bit       m_pend [N];
    bit       m_ack, m_valid, m_err;
    bit [7:0] m_code;
    int       served [$];

    function automatic bit [7:0] vec_of(int i);
        return 8'(BASE + 8'(i) * STEP);
    endfunction

    function automatic int winner();
        for (int i = 0; i < N; i++)
            if (m_pend[i] && dev_en[i]) return i;
        return -1;
    endfunction

    function automatic bit m_intr();
        return winner() >= 0;
    endfunction

    always @(posedge clk) begin
        int  w;
        bit  a;
        bit  line;
        if (rst) begin
            for (int i = 0; i < N; i++) m_pend[i] = 1'b0;
            m_ack = 0; m_valid = 0; m_err = 0; m_code = 8'h00;
        end else begin
            w    = winner();
            a    = m_ack;
            line = m_intr();
            m_valid = a && (w >= 0);
            m_err   = a && (w < 0);
            if (a) begin
                m_code = (w >= 0) ? vec_of(w) : 8'h00;
                if (w >= 0) served.push_back(w);
            end
            for (int i = 0; i < N; i++) begin
                if (dev_raise[i]) m_pend[i] = 1'b1;
                else if (a && i == w) m_pend[i] = 1'b0;
            end
            m_ack = !a && line && cpu_ready;
        end
    end

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int w;
        w = winner();
        check("R1", "intr_line", {7'b0, intr_line}, {7'b0, m_intr()});
        check("R4", "int_ack", {7'b0, int_ack}, {7'b0, m_ack});
        check("R7", "data_bus", data_bus, (m_ack && w >= 0) ? vec_of(w) : 8'h00);
        check("R8", "vec_valid", {7'b0, vec_valid}, {7'b0, m_valid});
        check("R8", "vec_code", vec_code, m_code);
        check("R10", "ack_error", {7'b0, ack_error}, {7'b0, m_err});
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic pulse(logic [N-1:0] mask);
        dev_raise = mask;
        cyc();
        dev_raise = '0;
    endtask

    task automatic wait_ack();
        for (int k = 0; k < 50 && !m_ack; k++) cyc();
    endtask

    task automatic drain(int cycles);
        for (int k = 0; k < cycles; k++) cyc();
    endtask

    initial begin
        // R11: reset state
        cpu_ready = 1'b1;
        dev_raise = '1;
        drain(3);
        dev_raise = '0;
        drain(1);
        rst = 1'b0;
        check("R11", "intr after reset", {7'b0, intr_line}, 8'h00);
        check("R11", "vec_code after reset", vec_code, 8'h00);

        // R2 R4 R7 R8: single request on cell 3
        phase = "R2_single";
        pulse(6'b001000);
        check("R2", "line up after raise", {7'b0, intr_line}, 8'h01);
        cyc();
        check("R7", "bus in ack", data_bus, vec_of(3));
        cyc();
        check("R8", "code latched", vec_code, vec_of(3));
        check("R8", "line cleared", {7'b0, intr_line}, 8'h00);
        drain(2);

        // R6: simultaneous requests served nearest first
        phase = "R6_order";
        served.delete();
        pulse(6'b110010);
        drain(12);
        check("R6", "served count", 8'(served.size()), 8'd3);
        if (served.size() == 3) begin
            check("R6", "first", 8'(served[0]), 8'd1);
            check("R6", "second", 8'(served[1]), 8'd4);
            check("R6", "third", 8'(served[2]), 8'd5);
        end

        // R5: processor not ready holds off the acknowledge
        phase = "R5_stall";
        cpu_ready = 1'b0;
        pulse(6'b000100);
        drain(6);
        check("R5", "no ack while busy", {7'b0, int_ack}, 8'h00);
        check("R5", "request held", {7'b0, intr_line}, 8'h01);
        cpu_ready = 1'b1;
        drain(4);

        // R3: masked cell is skipped but kept
        phase = "R3_mask";
        served.delete();
        dev_en = 6'b111110;
        pulse(6'b000101);
        drain(6);
        check("R3", "masked line low", {7'b0, intr_line}, 8'h00);
        dev_en = '1;
        drain(5);
        check("R3", "served count", 8'(served.size()), 8'd2);
        if (served.size() == 2) begin
            check("R3", "unmasked first", 8'(served[0]), 8'd2);
            check("R3", "masked later", 8'(served[1]), 8'd0);
        end

        // R9: raises colliding with the acknowledge cycle
        phase = "R9_collide";
        served.delete();
        pulse(6'b001000);
        wait_ack();
        dev_raise = 6'b001001;
        cyc();
        dev_raise = '0;
        check("R9", "winner vector kept", vec_code, vec_of(3));
        drain(10);
        check("R9", "served count", 8'(served.size()), 8'd3);

        // R10: acknowledge with no responder
        phase = "R10_empty";
        pulse(6'b000100);
        wait_ack();
        dev_en = 6'b111011;
        cyc();
        check("R10", "error flagged", {7'b0, ack_error}, 8'h01);
        dev_en = '1;
        drain(5);
        check("R10", "late service code", vec_code, vec_of(2));

        // mixed random traffic
        phase = "R6_random";
        for (int k = 0; k < 400; k++) begin
            dev_raise = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            dev_en    = ($urandom_range(0, 5) == 0) ? N'($urandom) : '1;
            cpu_ready = ($urandom_range(0, 3) != 0);
            cyc();
        end
        dev_raise = '0;
        dev_en = '1;
        cpu_ready = 1'b1;
        drain(20);
        check("R1", "drained", {7'b0, intr_line}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule